// File: doc/BRIEF.md
# Paired-Channel PWM Timer Output Stage

This block is the output side of a four-channel timer that counts up. One free-running counter counts from zero to a period value and then wraps. Each channel compares the counter with its own compare value and produces a pulse-width reference. The channels work in pairs (0 with 1, 2 with 3). A channel in a combined mode merges its own reference with the plain reference of its partner, using AND or OR. Two compare values then set the rising edge and the falling edge of a pulse on their own, so pulses that are off-centre can be placed anywhere in the period.

Each channel can be held low by an external clear signal. When the channel's clear enable is set and the selected clear source is high, the channel output goes low. It stays low until the counter next wraps, even if the source drops before then. A global select bit takes the clear source either from a dedicated clear pin or from a filtered external trigger pin.

Software programs the block through a plain register write port with no back-pressure: a write is accepted in the cycle where `wr_en` is high. Period and compare values are double-buffered and take effect at the wrap. Mode, clear enable, run and source select take effect at once. The block has no streaming data path, so it has no valid/ready interface.

Top module: `pwm_pair_timer`

## Requirements
- R1: After reset all outputs are low, the counter is stopped at zero, and every period, compare and control register is zero.
- R2: With the run bit (bit 0 of the global register at address 9) set, the counter steps by one each cycle from 0 to the active period and then wraps to 0. The wrap is the update event. With run clear, the counter and all outputs keep their values.
- R3: Writes to the period register (address 0) and the compare registers (address 1+n for channel n) are stored in shadows. The active copies load only at the update event.
- R4: Each output is registered and reflects the counter value of the previous cycle. In PWM mode 1 (code 0110) the output is high while counter < compare. In PWM mode 2 (code 0111) it is high while counter >= compare.
- R5: Code 0100 forces the output low. Code 0101 forces it high.
- R6: Combined mode 1 (code 1100) outputs the OR of the channel's own mode-1 reference and its partner's plain reference. The partner's plain reference is its mode-1 or mode-2 comparison, chosen by bit 0 of the partner's code.
- R7: Combined mode 2 (code 1101) outputs the AND of the channel's own mode-2 reference and its partner's plain reference.
- R8: The control register of channel n (address 5+n) holds the mode code with its low three bits in bits 2:0 and its top bit in bit 4. Any code not listed in R4 to R7 drives the output low.
- R9: With the clear enable (control bit 3) set in a PWM or combined mode, a high clear source drives the output low from the next cycle. The output stays low until the update event, even after the source returns low.
- R10: In the forced modes the clear source has no effect on the output.
- R11: Bit 1 of the global register selects the clear source: 0 selects `clr_in` and 1 selects `ext_trig_in`. The source that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| clr_in | input | 1 | Dedicated clear input |
| ext_trig_in | input | 1 | Filtered external trigger, usable as clear source |
| pwm_o | output | 4 | Channel outputs |

## Verification
The hardest case to reach from the ports is a clear that arrives in the middle of a period. The state has no pin of its own, and the clear must be seen to outlast its source and to release exactly at the wrap. The bench sets one channel of a pair to a one-cycle pulse at counter zero and uses that pin as a phase marker. It then times a single-cycle clear pulse a few counts into the period and checks that the cleared pin stays low until the marker pulses again. A behavioural model compares every pin on every cycle. The bench also measures pulse widths over whole periods for several AND and OR compare pairs.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  typedef enum logic [3:0] {
    MD_FORCE_LO = 4'b0100,
    MD_FORCE_HI = 4'b0101,
    MD_PWM1     = 4'b0110,
    MD_PWM2     = 4'b0111,
    MD_COMB_OR  = 4'b1100,
    MD_COMB_AND = 4'b1101
  } mode_e;

  function automatic logic mode_clearable(input logic [3:0] m);
    return (m == MD_PWM1) || (m == MD_PWM2) || (m == MD_COMB_OR) || (m == MD_COMB_AND);
  endfunction

  // field positions in a channel control word
  localparam int CTL_CE_BIT  = 3;
  localparam int CTL_MSB_BIT = 4;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16,
  parameter int NCH   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic [CNT_W-1:0]           per_pre,
  input  logic [NCH-1:0][CNT_W-1:0]  cmp_pre,
  output logic [CNT_W-1:0]           cnt,
  output logic [NCH-1:0][CNT_W-1:0]  cmp_act,
  output logic                       upd
);
  logic [CNT_W-1:0] per_act;

  assign upd = run && (cnt == per_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_act <= '0;
      cmp_act <= '0;
    end else if (run) begin
      if (upd) begin
        cnt     <= '0;
        per_act <= per_pre;
        cmp_act <= cmp_pre;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_act); // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (cnt == '0)); // R2
  AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(cmp_act)); // R3
  AST_PER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(per_act)); // R3
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [3:0]       mode,
  input  logic             clr_en,
  input  logic             clr_src,
  input  logic             upd,
  input  logic             partner_base,
  output logic             base_o,
  output logic             out_o
);
  logic lt, ge, ref_c, clearable, trig, hold_q;

  assign lt        = cnt < cmp;
  assign ge        = !lt;
  assign base_o    = mode[0] ? ge : lt;
  assign clearable = mode_clearable(mode);
  assign trig      = clr_en && clr_src && clearable;

  always_comb begin
    unique case (mode)
      MD_PWM1:     ref_c = lt;
      MD_PWM2:     ref_c = ge;
      MD_COMB_OR:  ref_c = lt | partner_base;
      MD_COMB_AND: ref_c = ge & partner_base;
      MD_FORCE_HI: ref_c = 1'b1;
      default:     ref_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      out_o  <= 1'b0;
    end else begin
      if (upd)       hold_q <= 1'b0;
      else if (trig) hold_q <= 1'b1;
      if (run) out_o <= ref_c && !(clearable && (hold_q || trig));
    end
  end

  AST_HOLD_UNTIL_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !upd) |=> hold_q); // R9
  AST_CLEAR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && trig) |=> !out_o); // R9
  AST_FORCED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == MD_FORCE_HI) |=> out_o); // R10
  AST_FORCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == MD_FORCE_LO) |=> !out_o); // R5
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              clr_in,
  input  logic              ext_trig_in,
  output logic [NCH-1:0]    pwm_o
);
  localparam int A_PER  = 0;
  localparam int A_CMP0 = 1;
  localparam int A_CTL0 = A_CMP0 + NCH;
  localparam int A_GLB  = A_CTL0 + NCH;

  logic [CNT_W-1:0]          per_pre;
  logic [NCH-1:0][CNT_W-1:0] cmp_pre;
  logic [NCH-1:0][CNT_W-1:0] cmp_act;
  logic [NCH-1:0][3:0]       mode_q;
  logic [NCH-1:0]            ce_q;
  logic                      run_q, sel_q;
  logic [CNT_W-1:0]          cnt;
  logic                      upd, clr_src;
  logic [NCH-1:0]            base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_pre <= '0;
      cmp_pre <= '0;
      mode_q  <= '0;
      ce_q    <= '0;
      run_q   <= 1'b0;
      sel_q   <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_PER)) per_pre <= wr_data;
      if (wr_addr == ADDR_W'(A_GLB)) begin
        run_q <= wr_data[0];
        sel_q <= wr_data[1];
      end
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == ADDR_W'(A_CMP0 + i)) cmp_pre[i] <= wr_data;
        if (wr_addr == ADDR_W'(A_CTL0 + i)) begin
          mode_q[i] <= {wr_data[CTL_MSB_BIT], wr_data[2:0]};
          ce_q[i]   <= wr_data[CTL_CE_BIT];
        end
      end
    end
  end

  assign clr_src = sel_q ? ext_trig_in : clr_in;

  pwm_timebase #(.CNT_W(CNT_W), .NCH(NCH)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run_q), .per_pre(per_pre),
    .cmp_pre(cmp_pre), .cnt(cnt), .cmp_act(cmp_act), .upd(upd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run_q), .cnt(cnt), .cmp(cmp_act[g]),
      .mode(mode_q[g]), .clr_en(ce_q[g]), .clr_src(clr_src), .upd(upd),
      .partner_base(base[g ^ 1]), .base_o(base[g]), .out_o(pwm_o[g])
    );
  end

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(pwm_o)); // R2
endmodule

// File: tb/tb_pwm_pair_timer.sv
module tb_pwm_pair_timer;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic        clr_in = 0, ext_trig_in = 0;
  logic [3:0]  pwm_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  pwm_pair_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clr_in(clr_in), .ext_trig_in(ext_trig_in), .pwm_o(pwm_o));

  always #2 clk = ~clk; // 250 MHz

  // behavioural reference model
  int m_cnt, m_per_act, m_per_pre;
  int m_cmp_act[4], m_cmp_pre[4];
  int m_mode[4];
  bit m_ce[4], m_hold[4];
  bit m_run, m_sel;
  bit [3:0] m_out;

  function automatic bit plain_ref(int ch);
    return (m_mode[ch] % 2 == 1) ? (m_cnt >= m_cmp_act[ch]) : (m_cnt < m_cmp_act[ch]);
  endfunction

  function automatic bit is_clr_mode(int md);
    return md == 6 || md == 7 || md == 12 || md == 13;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_per_act = 0; m_per_pre = 0; m_run = 0; m_sel = 0; m_out = 0;
      for (int i = 0; i < 4; i++) begin
        m_cmp_act[i] = 0; m_cmp_pre[i] = 0; m_mode[i] = 0; m_ce[i] = 0; m_hold[i] = 0;
      end
    end else begin
      bit u, src;
      bit [3:0] nxt;
      u = m_run && (m_cnt == m_per_act);
      src = m_sel ? ext_trig_in : clr_in;
      nxt = m_out;
      for (int i = 0; i < 4; i++) begin
        bit r, t;
        case (m_mode[i])
          6:  r = m_cnt < m_cmp_act[i];
          7:  r = m_cnt >= m_cmp_act[i];
          12: r = (m_cnt < m_cmp_act[i]) || plain_ref(i ^ 1);
          13: r = (m_cnt >= m_cmp_act[i]) && plain_ref(i ^ 1);
          5:  r = 1;
          default: r = 0;
        endcase
        t = m_ce[i] && src && is_clr_mode(m_mode[i]);
        if (m_run) nxt[i] = r && !(m_hold[i] || t);
        if (u) m_hold[i] = 0; else if (t) m_hold[i] = 1;
      end
      m_out = nxt;
      if (m_run) begin
        if (u) begin
          m_cnt = 0; m_per_act = m_per_pre;
          for (int i = 0; i < 4; i++) m_cmp_act[i] = m_cmp_pre[i];
        end else m_cnt++;
      end
      if (wr_en) begin
        if (wr_addr == 0) m_per_pre = int'(wr_data);
        if (wr_addr == 9) begin m_run = wr_data[0]; m_sel = wr_data[1]; end
        for (int i = 0; i < 4; i++) begin
          if (wr_addr == 4'(1 + i)) m_cmp_pre[i] = int'(wr_data);
          if (wr_addr == 4'(5 + i)) begin
            m_mode[i] = int'({wr_data[4], wr_data[2:0]});
            m_ce[i] = wr_data[3];
          end
        end
      end
    end
  end

  function automatic string tag_of(int ch);
    if (m_hold[ch]) return "R9";
    case (m_mode[ch])
      6, 7: return "R4";
      4, 5: return "R5";
      12: return "R6";
      13: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        n_chk++;
        if (pwm_o[i] !== m_out[i]) begin
          n_bad++;
          $display("FAIL %s ch%0d cycle %0d: actual %b expected %b", tag_of(i), i, cyc, pwm_o[i], m_out[i]);
        end
      end
    end
    if (cyc > 100000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic int ctl(int md, int ce);
    return ((md >> 3) & 1) << 4 | (ce << 3) | (md & 7);
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic width(int ch, int per, output int w);
    w = 0;
    for (int k = 0; k <= per; k++) begin
      @(negedge clk);
      if (pwm_o[ch]) w++;
    end
  endtask

  localparam int P = 9;

  initial begin
    int w, e;
    int a_and[3] = '{2, 5, 0};
    int b_and[3] = '{7, 5, 10};
    int a_or[3]  = '{3, 0, 8};
    int b_or[3]  = '{6, 10, 2};
    idle(3);
    check("R1 reset out", int'(pwm_o), 0);
    rst_n = 1;
    idle(2);
    check("R1 after reset", int'(pwm_o), 0);

    wr(0, P);
    wr(9, 1);
    for (int t = 0; t < 3; t++) begin
      wr(1, a_and[t]); wr(2, b_and[t]); wr(3, a_or[t]); wr(4, b_or[t]);
      wr(5, ctl(13, 0)); wr(6, ctl(6, 0)); wr(7, ctl(12, 0)); wr(8, ctl(7, 0));
      idle(2 * (P + 1));
      e = 0; for (int c = 0; c <= P; c++) if (c >= a_and[t] && c < b_and[t]) e++;
      width(0, P, w); check("R7 AND width", w, e);
      e = 0; for (int c = 0; c <= P; c++) if (c < a_or[t] || c >= b_or[t]) e++;
      width(2, P, w); check("R6 OR width", w, e);
      width(1, P, w); check("R4 mode1 width", w, b_and[t] > P + 1 ? P + 1 : b_and[t]);
      width(3, P, w); check("R4 mode2 width", w, (P + 1 > b_or[t]) ? P + 1 - b_or[t] : 0);
    end

    // R8: invalid code drives low
    wr(6, ctl(3, 0)); idle(P + 2);
    width(1, P, w); check("R8 invalid code", w, 0);

    // R9: mid-period clear, ch1 as phase marker (high only at counter 0)
    wr(1, 8); wr(2, 1); wr(5, ctl(6, 1)); wr(6, ctl(6, 0));
    idle(2 * (P + 1));
    while (pwm_o[1] !== 1'b1) @(negedge clk);
    @(negedge clk); clr_in = 1;
    @(negedge clk); clr_in = 0;
    idle(3);
    check("R9 held low after clear", int'(pwm_o[0]), 0);
    while (pwm_o[1] !== 1'b1) @(negedge clk);
    check("R9 released at update", int'(pwm_o[0]), 1);

    // R10: forced high ignores clear
    wr(7, ctl(5, 1));
    idle(2);
    clr_in = 1; idle(3);
    check("R10 forced high with clear", int'(pwm_o[2]), 1);
    clr_in = 0;
    wr(7, ctl(4, 1)); idle(2);
    check("R5 forced low", int'(pwm_o[2]), 0);

    // R11: source select
    idle(2 * (P + 1));
    while (pwm_o[1] !== 1'b1) @(negedge clk);
    @(negedge clk); ext_trig_in = 1;
    @(negedge clk); ext_trig_in = 0;
    idle(2);
    check("R11 unselected ext ignored", int'(pwm_o[0]), 1);
    wr(9, 3);
    while (pwm_o[1] !== 1'b1) @(negedge clk);
    @(negedge clk); ext_trig_in = 1;
    @(negedge clk); ext_trig_in = 0;
    idle(2);
    check("R11 selected ext clears", int'(pwm_o[0]), 0);
    @(negedge clk); clr_in = 1;
    @(negedge clk); clr_in = 0;

    // R3: compare written mid-period takes effect only at wrap
    wr(9, 1);
    idle(2 * (P + 1));
    while (pwm_o[1] !== 1'b1) @(negedge clk);
    wr(1, 3);
    width(0, P, w); check("R3 old compare still active", w, 8);
    idle(P + 1);
    width(0, P, w); check("R3 new compare after update", w, 3);

    // R2: stopped counter freezes outputs
    wr(9, 0);
    e = int'(pwm_o);
    idle(15);
    check("R2 stopped frozen", int'(pwm_o), e);
    wr(9, 1); idle(20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule